// File: doc/BRIEF.md
# Programmable PLL Lock Detector

This block decides whether a frequency synthesizer has settled. Once per reference-oscillator period the phase-frequency detector's up and down flags are presented together with a one-clock strobe. A flag that is high on a single strobe is an ordinary correction pulse. A flag that stays high on two strobes in a row marks the reference period as bad. A long enough run of good periods raises the lock output. A long enough run of bad periods can lower it again. Each of the two run lengths is chosen by its own 2-bit code, and the codes map to powers of two.

A mode input picks how the output behaves after lock. In one-shot mode the first lock is final and the output stays high. In tracking mode the detector keeps watching, so the output can fall and rise again. A restart input clears the detector. The surrounding control logic pulses it when the synthesizer leaves standby or when the receive/transmit divider set is swapped. The block also gates the power-amplifier enable during transmit. That enable waits for lock unless a force input is set.

Top module: `pll_lock_detect`

## Requirements
- R1: The lock code maps 00 to 4, 01 to 16, 10 to 64 and 11 to 256 consecutive good strobes. The lock output rises on the clock edge that samples the strobe completing the run, and not one strobe sooner.
- R2: The unlock code maps 00 to 2, 01 to 4, 10 to 8 and 11 to 16 consecutive bad strobes. In tracking mode (mode = 1) the lock output falls on the edge that samples the strobe completing that run, and not one strobe sooner.
- R3: A strobe is bad when up is high on it and was also high on the previous strobe, or when down is high on it and was also high on the previous strobe. Every other strobe is good. A bad strobe zeroes the good run, and a good strobe zeroes the bad run.
- R4: In one-shot mode (mode = 0) the lock output stays high after the first lock, whatever bad strobes follow.
- R5: In tracking mode, after an unlock the output rises again only after a full new run of good strobes of the programmed length.
- R6: A restart pulse clears the lock output, both runs and the remembered previous flags. The lock output is low on the next edge.
- R7: The PA enable equals tx_active AND (pa_force OR lock_out). It is combinational from these inputs and the registered lock output.
- R8: Clock cycles without a strobe change nothing, whatever the up and down flags do.
- R9: After reset the lock output is low and both runs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-clock strobe, once per reference period |
| pfd_up | input | 1 | Phase detector up flag, sampled on a strobe |
| pfd_dn | input | 1 | Phase detector down flag, sampled on a strobe |
| lock_sel | input | 2 | Lock run-length code (00:4, 01:16, 10:64, 11:256) |
| unlock_sel | input | 2 | Unlock run-length code (00:2, 01:4, 10:8, 11:16) |
| watch_mode | input | 1 | 0 one-shot, 1 tracking |
| pa_force | input | 1 | 1 keeps the PA on during transmit regardless of lock |
| tx_active | input | 1 | Transmit in progress |
| restart | input | 1 | Synchronous clear of the detector state |
| lock_out | output | 1 | Registered lock indication |
| pa_en | output | 1 | Power-amplifier enable |

## Verification
The hardest behaviour to reach from the ports is a bad strobe. It needs the same flag high on two strobes, and the first of those two strobes still counts as good. A bench that simply holds a flag high therefore always sees one good strobe before each bad run. The stimulus accounts for this: each bad run starts with a quiet strobe and a single priming strobe, which makes the exact bad-strobe count that triggers unlock predictable. The same effect is used to check that restart clears the remembered flags. The bench repeats a flag across a restart and verifies that the strobe after the restart is counted as good.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_TRACK   = 1'b1
    } watch_e;

    // Largest exponent a code field can select: base + step * (all ones).
    function automatic int max_log(input int base_log, input int step_log, input int code_w);
        return base_log + step_log * ((1 << code_w) - 1);
    endfunction

endpackage

// File: rtl/pld_cycle_judge.sv
module pld_cycle_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic up,
    input  logic dn,
    output logic good_o,
    output logic bad_o
);

    typedef struct packed {
        logic prev_up;
        logic prev_dn;
    } judge_t;

    judge_t st_q, st_d;
    logic   held;

    always_comb begin
        st_d   = st_q;
        held   = (up && st_q.prev_up) || (dn && st_q.prev_dn);
        good_o = 1'b0;
        bad_o  = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            st_d.prev_up = up;
            st_d.prev_dn = dn;
            bad_o        = held;
            good_o       = !held;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_exclusive_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_o && bad_o));

    assert_idle_memory_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q));

endmodule

// File: rtl/pld_run_counter.sv
module pld_run_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          hit,
    input  logic [CW-1:0] limit,
    output logic          reach_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_t;

    run_t        st_q, st_d;
    logic [CW:0] inc;

    always_comb begin
        st_d    = st_q;
        inc     = {1'b0, st_q.cnt} + 1'b1;
        reach_o = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (hit) begin
                reach_o  = (inc >= {1'b0, limit});
                st_d.cnt = (st_q.cnt >= limit) ? limit : inc[CW-1:0];
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_run_broken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit && !clr) |=> (st_q.cnt == '0));

    assert_no_strobe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/pld_lock_state.sv
module pld_lock_state (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic watch_mode,
    input  logic lock_hit,
    input  logic unlock_hit,
    output logic lock_o
);

    typedef struct packed {
        logic locked;
    } lock_t;

    lock_t st_q, st_d;
    logic  tracking;

    always_comb begin
        st_d     = st_q;
        tracking = (watch_mode == pld_pkg::MODE_TRACK);
        if (clr) begin
            st_d.locked = 1'b0;
        end else if (st_q.locked) begin
            if (tracking && unlock_hit) st_d.locked = 1'b0;
        end else if (lock_hit) begin
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.locked;

    assert_rise_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(lock_hit));

    assert_oneshot_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !watch_mode && !clr) |=> st_q.locked);

    assert_track_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && watch_mode && unlock_hit && !clr) |=> !st_q.locked);

    assert_restart_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.locked);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int CODE_W      = 2,
    parameter int LK_BASE_LOG = 2,
    parameter int LK_STEP_LOG = 2,
    parameter int UL_BASE_LOG = 1,
    parameter int UL_STEP_LOG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              pfd_up,
    input  logic              pfd_dn,
    input  logic [CODE_W-1:0] lock_sel,
    input  logic [CODE_W-1:0] unlock_sel,
    input  logic              watch_mode,
    input  logic              pa_force,
    input  logic              tx_active,
    input  logic              restart,
    output logic              lock_out,
    output logic              pa_en
);

    localparam int LK_CW = pld_pkg::max_log(LK_BASE_LOG, LK_STEP_LOG, CODE_W) + 1;
    localparam int UL_CW = pld_pkg::max_log(UL_BASE_LOG, UL_STEP_LOG, CODE_W) + 1;

    logic [LK_CW-1:0] lk_limit;
    logic [UL_CW-1:0] ul_limit;
    logic             good, bad, lock_hit, unlock_hit;

    assign lk_limit = LK_CW'(1) << (LK_BASE_LOG + LK_STEP_LOG * int'(lock_sel));
    assign ul_limit = UL_CW'(1) << (UL_BASE_LOG + UL_STEP_LOG * int'(unlock_sel));

    pld_cycle_judge u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .tick   (ref_tick),
        .up     (pfd_up),
        .dn     (pfd_dn),
        .good_o (good),
        .bad_o  (bad)
    );

    pld_run_counter #(.CW(LK_CW)) u_good_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .tick    (ref_tick),
        .hit     (good),
        .limit   (lk_limit),
        .reach_o (lock_hit)
    );

    pld_run_counter #(.CW(UL_CW)) u_bad_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .tick    (ref_tick),
        .hit     (bad),
        .limit   (ul_limit),
        .reach_o (unlock_hit)
    );

    pld_lock_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (restart),
        .watch_mode (watch_mode),
        .lock_hit   (lock_hit),
        .unlock_hit (unlock_hit),
        .lock_o     (lock_out)
    );

    always_comb begin
        pa_en = tx_active && (pa_force || lock_out);
    end

    assert_pa_waits_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !pa_force && !lock_out) |-> !pa_en);

    assert_pa_off_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !pa_en);

endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, pfd_up = 1'b0, pfd_dn = 1'b0;
    logic [1:0] lock_sel = 2'd0, unlock_sel = 2'd0;
    logic       watch_mode = 1'b0, pa_force = 1'b0, tx_active = 1'b0, restart = 1'b0;
    logic       lock_out, pa_en;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pll_lock_detect dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
        .lock_sel(lock_sel), .unlock_sel(unlock_sel), .watch_mode(watch_mode),
        .pa_force(pa_force), .tx_active(tx_active), .restart(restart),
        .lock_out(lock_out), .pa_en(pa_en)
    );

    // {mode, lock code, unlock code, good run length, bad run length, lock after bad run}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 2'd0, 2'd0, 9'd4,   5'd2,  1'b1},
        {1'b1, 2'd0, 2'd0, 9'd4,   5'd2,  1'b0},
        {1'b1, 2'd1, 2'd1, 9'd16,  5'd4,  1'b0},
        {1'b0, 2'd1, 2'd2, 9'd16,  5'd8,  1'b1},
        {1'b1, 2'd2, 2'd3, 9'd64,  5'd16, 1'b0},
        {1'b0, 2'd2, 2'd1, 9'd64,  5'd4,  1'b1},
        {1'b1, 2'd3, 2'd2, 9'd256, 5'd8,  1'b0},
        {1'b0, 2'd3, 2'd3, 9'd256, 5'd16, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tk(input logic u, input logic d);
        @(negedge clk);
        ref_tick = 1'b1; pfd_up = u; pfd_dn = d;
        @(negedge clk);
        ref_tick = 1'b0; pfd_up = 1'b0; pfd_dn = 1'b0;
    endtask

    task automatic good_run(input int n);
        for (int i = 0; i < n; i++) tk(i % 4 == 1, i % 4 == 3);
    endtask

    // quiet strobe, priming strobe (still good), then n bad strobes
    task automatic bad_run(input int n);
        tk(1'b0, 1'b0);
        tk(1'b1, 1'b0);
        for (int i = 0; i < n; i++) tk(1'b1, 1'b0);
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state, R7 PA gating
        check(lock_out, 1'b0, "R9 lock low after reset");
        tx_active = 1'b1; #1;
        check(pa_en, 1'b0, "R7 PA waits for lock");
        pa_force = 1'b1; #1;
        check(pa_en, 1'b1, "R7 PA forced in transmit");
        tx_active = 1'b0; #1;
        check(pa_en, 1'b0, "R7 PA off outside transmit");
        pa_force = 1'b0;

        // table walk: R1, R2, R4, R5
        for (int k = 0; k < 8; k++) begin
            logic [19:0] v;
            int lk_n, ul_n;
            v = VEC[k];
            watch_mode = v[19]; lock_sel = v[18:17]; unlock_sel = v[16:15];
            lk_n = int'(v[14:6]); ul_n = int'(v[5:1]);
            do_restart();
            good_run(lk_n - 1);
            check(lock_out, 1'b0, "R1 one good strobe short");
            good_run(1);
            check(lock_out, 1'b1, "R1 full good run");
            bad_run(ul_n - 1);
            check(lock_out, 1'b1, "R2 one bad strobe short");
            tk(1'b1, 1'b0);
            check(lock_out, v[0], v[19] ? "R2 tracking unlock" : "R4 one-shot holds");
            if (v[19]) begin
                good_run(lk_n - 1);
                check(lock_out, 1'b0, "R5 relock needs full run");
                tk(1'b0, 1'b0);
                check(lock_out, 1'b1, "R5 relock after full run");
            end
        end

        // R3: bad strobe breaks the good run
        watch_mode = 1'b1; lock_sel = 2'd0; unlock_sel = 2'd3;
        do_restart();
        tk(0, 0); tk(0, 0); tk(1, 0); tk(1, 0);
        tk(0, 0); tk(0, 0); tk(0, 0);
        check(lock_out, 1'b0, "R3 bad strobe zeroed good run");
        tk(0, 0);
        check(lock_out, 1'b1, "R3 lock after fresh good run");

        // R3: alternating single pulses are good
        do_restart();
        tk(1, 0); tk(0, 1); tk(1, 0); tk(0, 1);
        check(lock_out, 1'b1, "R3 single pulses count as good");

        // R3: good strobe breaks the bad run (unlock run 2)
        unlock_sel = 2'd0;
        tk(1, 0); tk(1, 0); tk(0, 0); tk(1, 0); tk(1, 0);
        check(lock_out, 1'b1, "R3 good strobe zeroed bad run");
        tk(1, 0);
        check(lock_out, 1'b0, "R3 two consecutive bad strobes unlock");

        // R8: no strobe, no change
        do_restart();
        good_run(4);
        @(negedge clk); pfd_up = 1'b1; pfd_dn = 1'b1;
        repeat (20) @(negedge clk);
        pfd_up = 1'b0; pfd_dn = 1'b0;
        check(lock_out, 1'b1, "R8 held flags without strobe ignored");
        do_restart();
        good_run(3);
        @(negedge clk); pfd_dn = 1'b1;
        repeat (10) @(negedge clk);
        pfd_dn = 1'b0;
        check(lock_out, 1'b0, "R8 idle cycles add nothing");
        tk(0, 0);
        check(lock_out, 1'b1, "R8 run resumed across idle cycles");

        // R6: restart clears lock, runs and previous flags
        watch_mode = 1'b0;
        do_restart();
        good_run(4);
        check(lock_out, 1'b1, "R6 setup one-shot lock");
        do_restart();
        check(lock_out, 1'b0, "R6 restart drops sticky lock");
        good_run(3);
        do_restart();
        good_run(3);
        check(lock_out, 1'b0, "R6 restart emptied good run");
        tk(0, 0);
        check(lock_out, 1'b1, "R6 lock after full run post restart");
        do_restart();
        tk(0, 0); tk(0, 0); tk(1, 0);
        do_restart();
        tk(1, 0); tk(0, 0); tk(0, 0); tk(0, 0);
        check(lock_out, 1'b1, "R6 restart forgot previous up flag");

        // R7: PA follows lock in transmit
        tx_active = 1'b1; pa_force = 1'b0; #1;
        check(pa_en, 1'b1, "R7 PA on once locked");
        do_restart(); #1;
        check(pa_en, 1'b0, "R7 PA off when lock lost");
        tx_active = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule